// File: doc/BRIEF.md
# Measurement Readout Port with Remote Conversion Control

This block connects an integrating converter to an external digital consumer. The converter's sequencer offers each finished reading over a valid/ready channel. The reading holds four BCD digits, the overrange, overload and polarity bits, a function code and a one-hot decimal-point field. The block latches the reading and drives it onto a 32-line output bus arranged as eight 4-bit groups. A flag marks the stable-data window. The bus also carries a divided clock tick and an inverted count-interval line. Each output line is a drive enable: a 1 means the open-collector transistor conducts. Each group drives only while its active-low strobe input is closed.

The block also decides when the sequencer converts. In free-run mode it asks for a new conversion whenever the sequencer is idle. A hold input freezes the published reading. A hold-at-end input lets the running conversion finish and then stops further starts. While hold-at-end is set, the falling edge of a trigger pulse starts exactly one conversion after a settling delay. All remote inputs pass through a synchronizer before use.

Result channel rules:
- Once `res_valid` is raised, it stays high with the data unchanged until a cycle in which `res_ready` is also high.
- `res_ready` never depends on `res_valid`.
- `res_ready` is low for the whole stable-data window. The sequencer must wait during that time.

Top module: `readout_port`

## Requirements
- R1: During and directly after reset, `res_ready` is 1, `flag` is 0, `conv_start` is 0, and every line of `drv` is 0, because all strobes count as open at reset.
- R2: `clk_tick` is a one-cycle pulse every CLK_DIV clock cycles. Line `drv[30]` carries the same value.
- R3: `count_n` equals the inverse of `count_active` one cycle later. Line `drv[29]` carries the same value.
- R4: When a result is accepted while hold is inactive, `res_ready` stays low for exactly FLAG_TICKS cycles, and the latched reading does not change in that time. A result offered during the window stays pending and is taken when the window ends.
- R5: The bus layout is fixed. Group g occupies `drv[4g+3:4g]`. Groups 0 to 3 carry BCD digits 0 to 3, with digit 0 the least significant. Group 4 carries {0, polarity (1 = positive), overload, overrange}. Group 5 carries {0, function code}. Group 6 carries the decimal-point field. Group 7 carries {0, tick, count_n, flag}.
- R6: `flag` rises with an accepted, unheld result and falls after FLAG_TICKS cycles. It also appears on `drv[28]`. Closing the flag-clear input forces `flag` low until the next accepted result. It does not shorten the window.
- R7: While hold is closed, offered results are still accepted but are thrown away, and the bus keeps its previous reading. After hold opens, the next accepted result is published.
- R8: With hold-at-end open, `conv_start` pulses for one cycle two cycles after `conv_busy` falls. No further start follows until `conv_busy` has gone high and then low again.
- R9: After hold-at-end closes, the running conversion completes and is published, and then no `conv_start` occurs.
- R10: With hold-at-end closed and the sequencer idle, a falling edge of `rc_trig` makes `conv_start` pulse once, SETTLE_TICKS+3 rising clock edges after the fall. This count includes two synchronizer stages and the edge detector.
- R11: A trigger release that arrives during the settle delay or during a triggered conversion is ignored.
- R12: Group g drives only while `rc_strobe_n[g]` is 0, two cycles after it changes. Otherwise the group's four lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Sequencer offers a result |
| res_ready | output | 1 | Block can take a result (low during window) |
| res_digits | input | 16 | Four BCD digits, digit 0 in bits 3:0 |
| res_ovr | input | 1 | Overrange digit |
| res_ovl | input | 1 | Overload bit |
| res_pos | input | 1 | Polarity, 1 = positive |
| res_func | input | 3 | Function code |
| res_dp | input | 4 | One-hot decimal-point position |
| conv_busy | input | 1 | Sequencer is converting |
| count_active | input | 1 | Sequencer is in its counting interval |
| conv_start | output | 1 | One-cycle request to start a conversion |
| rc_hold | input | 1 | Remote hold closure |
| rc_hold_eoc | input | 1 | Remote hold-at-end closure |
| rc_trig | input | 1 | Remote trigger closure (acts on release) |
| rc_flag_clr | input | 1 | Remote flag-clear closure |
| rc_strobe_n | input | 8 | Active-low per-group output strobes |
| clk_tick | output | 1 | Divided clock pulse |
| count_n | output | 1 | Low during the counting interval |
| flag | output | 1 | Stable-data flag |
| drv | output | 32 | Open-collector drive enables, eight 4-bit groups |

## Verification
The assertions assume the sequencer keeps the channel rules:
- It raises `conv_busy` in the cycle after `conv_start` and holds it until its result has been taken.
- It keeps `res_valid` and the data steady while `res_ready` is low.
- It drives `count_active` only while busy.

The assertions also assume that remote closures stay in place for at least three cycles. The bench's sequencer model follows exactly this handshake. All remote inputs are driven mid-cycle and held for several cycles, so every level reaches the synchronizer output before the next change.

// File: rtl/readout_pkg.sv
package readout_pkg;
  localparam int NIB_W      = 4;
  localparam int NUM_DIGITS = 4;
  localparam int NUM_GROUPS = 8;
  localparam int FUNC_W     = 3;
  localparam int DP_W       = 4;
  localparam int BUS_W      = NUM_GROUPS * NIB_W;
  localparam int READ_W     = NUM_DIGITS * NIB_W + 3 + FUNC_W + DP_W;

  typedef struct packed {
    logic [DP_W-1:0]                   dp;
    logic [FUNC_W-1:0]                 func;
    logic                              pos;
    logic                              ovl;
    logic                              ovr;
    logic [NUM_DIGITS-1:0][NIB_W-1:0]  digit;
  } reading_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_ACK   = 2'd2,
    ST_RUN   = 2'd3
  } seq_st_t;
endpackage

// File: rtl/readout_sync.sv
module readout_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/readout_ctrl.sv
module readout_ctrl
  import readout_pkg::*;
#(
  parameter int SETTLE_TICKS = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_eoc,
  input  logic trig,
  input  logic conv_busy,
  output logic conv_start
);
  localparam int SW = $clog2(SETTLE_TICKS + 1);

  seq_st_t       st;
  logic [SW-1:0] cnt;
  logic          trig_d;
  logic          trig_rel;
  logic          start_q;

  assign trig_rel   = trig_d & ~trig;
  assign conv_start = start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      trig_d  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      trig_d  <= trig;
      start_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (!hold_eoc && !conv_busy) begin
            start_q <= 1'b1;
            st      <= ST_ACK;
          end else if (hold_eoc && trig_rel) begin
            cnt <= SW'(SETTLE_TICKS - 1);
            st  <= ST_DELAY;
          end
        end
        ST_DELAY: begin
          if (cnt == '0) begin
            start_q <= 1'b1;
            st      <= ST_ACK;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ACK:  if (conv_busy)  st <= ST_RUN;
        ST_RUN:  if (!conv_busy) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/readout_result.sv
module readout_result
  import readout_pkg::*;
#(
  parameter int FLAG_TICKS = 30_000_000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  reading_t in_data,
  input  logic     hold,
  input  logic     flag_clr,
  output reading_t cur,
  output logic     flag
);
  localparam int CW = $clog2(FLAG_TICKS + 1);

  logic [CW-1:0] win;

  assign in_ready = (win == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win  <= '0;
      flag <= 1'b0;
      cur  <= '0;
    end else if (in_valid && in_ready && !hold) begin
      cur  <= in_data;
      win  <= CW'(FLAG_TICKS);
      flag <= ~flag_clr;
    end else begin
      if (win != '0) win <= win - 1'b1;
      if (flag_clr || win == CW'(1)) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/readout_gate.sv
module readout_gate
  import readout_pkg::*;
(
  input  logic [BUS_W-1:0]      word,
  input  logic [NUM_GROUPS-1:0] en,
  output logic [BUS_W-1:0]      drv
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign drv[g*NIB_W +: NIB_W] = en[g] ? word[g*NIB_W +: NIB_W] : '0;
  end
endmodule

// File: rtl/readout_port.sv
module readout_port
  import readout_pkg::*;
#(
  parameter int CLK_DIV      = 1000,
  parameter int FLAG_TICKS   = 30_000_000,
  parameter int SETTLE_TICKS = 10_000_000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        res_valid,
  output logic                        res_ready,
  input  logic [NUM_DIGITS*NIB_W-1:0] res_digits,
  input  logic                        res_ovr,
  input  logic                        res_ovl,
  input  logic                        res_pos,
  input  logic [FUNC_W-1:0]           res_func,
  input  logic [DP_W-1:0]             res_dp,
  input  logic                        conv_busy,
  input  logic                        count_active,
  output logic                        conv_start,
  input  logic                        rc_hold,
  input  logic                        rc_hold_eoc,
  input  logic                        rc_trig,
  input  logic                        rc_flag_clr,
  input  logic [NUM_GROUPS-1:0]       rc_strobe_n,
  output logic                        clk_tick,
  output logic                        count_n,
  output logic                        flag,
  output logic [BUS_W-1:0]            drv
);
  localparam int RC_W = NUM_GROUPS + 4;
  localparam int DIVW = $clog2(CLK_DIV);
  localparam int G_ST = NUM_DIGITS;

  logic [RC_W-1:0]       rc_raw, rc_s;
  logic                  hold_s, eoc_s, trig_s, clr_s;
  logic [NUM_GROUPS-1:0] str_en;
  reading_t              in_rd, held;
  logic [BUS_W-1:0]      word;
  logic [DIVW-1:0]       div_cnt;

  assign rc_raw = {rc_strobe_n, rc_flag_clr, rc_trig, rc_hold_eoc, rc_hold};

  readout_sync #(
    .W      (RC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({{NUM_GROUPS{1'b1}}, 4'b0000})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (rc_raw),
    .q    (rc_s)
  );

  assign hold_s = rc_s[0];
  assign eoc_s  = rc_s[1];
  assign trig_s = rc_s[2];
  assign clr_s  = rc_s[3];
  assign str_en = ~rc_s[RC_W-1:4];

  assign in_rd.digit = res_digits;
  assign in_rd.ovr   = res_ovr;
  assign in_rd.ovl   = res_ovl;
  assign in_rd.pos   = res_pos;
  assign in_rd.func  = res_func;
  assign in_rd.dp    = res_dp;

  readout_result #(.FLAG_TICKS(FLAG_TICKS)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(res_valid),
    .in_ready(res_ready),
    .in_data (in_rd),
    .hold    (hold_s),
    .flag_clr(clr_s),
    .cur     (held),
    .flag    (flag)
  );

  readout_ctrl #(.SETTLE_TICKS(SETTLE_TICKS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_eoc  (eoc_s),
    .trig      (trig_s),
    .conv_busy (conv_busy),
    .conv_start(conv_start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      clk_tick <= 1'b0;
      count_n  <= 1'b1;
    end else begin
      count_n <= ~count_active;
      if (div_cnt == DIVW'(CLK_DIV - 1)) begin
        div_cnt  <= '0;
        clk_tick <= 1'b1;
      end else begin
        div_cnt  <= div_cnt + 1'b1;
        clk_tick <= 1'b0;
      end
    end
  end

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
    assign word[d*NIB_W +: NIB_W] = held.digit[d];
  end
  assign word[G_ST*NIB_W +: NIB_W]     = {1'b0, held.pos, held.ovl, held.ovr};
  assign word[(G_ST+1)*NIB_W +: NIB_W] = {1'b0, held.func};
  assign word[(G_ST+2)*NIB_W +: NIB_W] = held.dp;
  assign word[(G_ST+3)*NIB_W +: NIB_W] = {1'b0, clk_tick, count_n, flag};

  readout_gate u_gate (
    .word(word),
    .en  (str_en),
    .drv (drv)
  );
endmodule

// File: rtl/readout_chk.sv
module readout_chk
  import readout_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  res_ready,
  input logic                  flag,
  input logic                  conv_start,
  input logic                  clk_tick,
  input logic [BUS_W-1:0]      drv,
  input logic [NUM_GROUPS-1:0] str_en,
  input logic [READ_W-1:0]     held_bits
);
  function automatic logic [BUS_W-1:0] grp_mask(input logic [NUM_GROUPS-1:0] en);
    logic [BUS_W-1:0] m;
    for (int g = 0; g < NUM_GROUPS; g++) m[g*NIB_W +: NIB_W] = {NIB_W{en[g]}};
    return m;
  endfunction

  // R4: reading frozen while the window keeps the channel closed
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !res_ready |=> $stable(held_bits));

  // R6: flag only inside the window
  a_r6_flag_window: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> !res_ready);

  // R8: start request lasts one cycle
  a_r8_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R2: tick lasts one cycle
  a_r2_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    clk_tick |=> !clk_tick);

  // R12: closed groups stay silent
  a_r12_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (drv & ~grp_mask(str_en)) == '0);
endmodule

bind readout_port readout_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_ready (res_ready),
  .flag      (flag),
  .conv_start(conv_start),
  .clk_tick  (clk_tick),
  .drv       (drv),
  .str_en    (str_en),
  .held_bits (held)
);

// File: tb/sim_readout_port.sv
`timescale 1ns/1ps
module sim_readout_port;
  localparam int DIV = 10;
  localparam int FT  = 30;
  localparam int ST  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        res_valid, res_ready, conv_busy, count_active, conv_start;
  logic        rc_hold, rc_hold_eoc, rc_trig, rc_flag_clr;
  logic [7:0]  rc_strobe_n;
  logic        clk_tick, count_n, flag;
  logic [31:0] drv;
  logic [25:0] offer, last_acc;

  int checks = 0, fails = 0, acc_cnt = 0, starts = 0, max_wait = 0;
  bit reported = 0;

  readout_port #(.CLK_DIV(DIV), .FLAG_TICKS(FT), .SETTLE_TICKS(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_digits(offer[15:0]), .res_ovr(offer[16]), .res_ovl(offer[17]),
    .res_pos(offer[18]), .res_func(offer[21:19]), .res_dp(offer[25:22]),
    .conv_busy(conv_busy), .count_active(count_active), .conv_start(conv_start),
    .rc_hold(rc_hold), .rc_hold_eoc(rc_hold_eoc), .rc_trig(rc_trig),
    .rc_flag_clr(rc_flag_clr), .rc_strobe_n(rc_strobe_n),
    .clk_tick(clk_tick), .count_n(count_n), .flag(flag), .drv(drv));

  // expected groups 0..6 from a reading (R5 layout)
  function automatic logic [27:0] pack(input logic [25:0] r);
    return {r[25:22], 1'b0, r[21:19], 1'b0, r[18:16], r[15:0]};
  endfunction

  function automatic logic [25:0] rand_reading();
    logic [25:0] r;
    for (int i = 0; i < 4; i++) r[i*4 +: 4] = 4'($urandom % 10);
    r[16] = 1'($urandom % 2);
    r[17] = 1'($urandom % 2);
    r[18] = 1'($urandom % 2);
    r[21:19] = 3'($urandom % 5);
    r[25:22] = 4'b0001 << ($urandom % 4);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_acc();
    int a0 = acc_cnt;
    int guard = 0;
    while (acc_cnt == a0 && guard < 500) begin step(1); guard++; end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
  endtask

  // sequencer model
  initial begin
    conv_busy = 0; count_active = 0; res_valid = 0; offer = '0; last_acc = '0;
    forever begin
      @(negedge clk);
      if (rst_n && conv_start) begin
        int w = 0;
        starts++;
        conv_busy = 1; count_active = 1;
        repeat (8) @(negedge clk);
        count_active = 0;
        repeat (4) @(negedge clk);
        offer = rand_reading();
        res_valid = 1;
        while (!res_ready) begin @(negedge clk); w++; end
        if (w > max_wait) max_wait = w;
        @(negedge clk);
        acc_cnt++; last_acc = offer;
        res_valid = 0; conv_busy = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=finish", checks);
    report();
    $finish;
  end

  initial begin
    int n, s0, a0;
    logic [27:0] snap, expw;
    logic [31:0] ex;
    logic prev;
    bit frozen;
    void'($urandom(32'd2024));
    rc_hold = 0; rc_hold_eoc = 0; rc_trig = 0; rc_flag_clr = 0; rc_strobe_n = 8'hFF;
    step(3);
    // R1 reset state
    chk(res_ready == 1'b1, "R1 ready", 32'(res_ready), 32'd1);
    chk(flag == 1'b0 && conv_start == 1'b0, "R1 flag/start", {flag, conv_start}, 0);
    chk(drv == 32'h0, "R1 drv", drv, 0);
    rst_n = 1;
    step(1);
    chk(drv == 32'h0, "R1 drv after release", drv, 0);
    rc_strobe_n = 8'h00;
    step(3);

    // R2 tick period
    n = 0;
    while (!clk_tick && n < 50) begin step(1); n++; end
    chk(drv[30] == clk_tick, "R2 bus tick", 32'(drv[30]), 32'(clk_tick));
    n = 0;
    do begin step(1); n++; end while (!clk_tick && n < 50);
    chk(n == DIV, "R2 period", n, DIV);

    // R3 count interval
    for (int i = 0; i < 40; i++) begin
      prev = count_active;
      step(1);
      chk(count_n == ~prev && drv[29] == count_n, "R3 count_n", {drv[29], count_n}, {1'b0, ~prev});
    end

    // R4 / R6 window, R5 layout
    wait_acc();
    chk(flag && !res_ready && drv[28], "R6 flag at accept", {flag, res_ready, drv[28]}, 3'b101);
    chk(drv[27:0] == pack(last_acc), "R5 layout", drv[27:0], pack(last_acc));
    n = 0; snap = drv[27:0]; frozen = 1;
    while (!res_ready && n < 100) begin
      n++;
      if (drv[27:0] != snap) frozen = 0;
      step(1);
    end
    chk(n == FT, "R4 window length", n, FT);
    chk(frozen, "R4 frozen", 32'(frozen), 1);
    chk(flag == 1'b0, "R6 flag ends", 32'(flag), 0);
    for (int i = 0; i < 6; i++) begin
      wait_acc();
      chk(drv[27:0] == pack(last_acc), "R5 random reading", drv[27:0], pack(last_acc));
    end
    chk(max_wait > 0, "R4 back-pressure", max_wait, 1);

    // R8 free-run restart timing
    wait_acc();
    step(1);
    chk(conv_start == 1'b0, "R8 no early start", 32'(conv_start), 0);
    step(1);
    chk(conv_start == 1'b1, "R8 start", 32'(conv_start), 1);
    step(1);
    chk(conv_start == 1'b0, "R8 single cycle", 32'(conv_start), 0);

    // R6 flag clear
    wait_acc();
    step(1);
    rc_flag_clr = 1;
    step(4);
    chk(flag == 1'b0 && res_ready == 1'b0, "R6 cleared, window on", {flag, res_ready}, 0);
    rc_flag_clr = 0;
    step(4);
    chk(flag == 1'b0, "R6 stays cleared", 32'(flag), 0);
    wait_acc();
    chk(flag == 1'b1, "R6 next accept sets", 32'(flag), 1);

    // R7 hold
    rc_hold = 1;
    step(4);
    snap = drv[27:0];
    a0 = acc_cnt;
    n = 0;
    while (acc_cnt < a0 + 2 && n < 500) begin step(1); n++; end
    step(1);
    chk(drv[27:0] == snap, "R7 held reading", drv[27:0], snap);
    rc_hold = 0;
    step(3);
    wait_acc();
    chk(drv[27:0] == pack(last_acc), "R7 update after release", drv[27:0], pack(last_acc));

    // R9 hold at end of conversion
    rc_hold_eoc = 1;
    step(3);
    n = 0;
    while (conv_busy && n < 500) begin step(1); n++; end
    s0 = starts;
    step(200);
    chk(starts == s0 && !conv_busy, "R9 no new start", starts, s0);
    chk(drv[27:0] == pack(last_acc), "R9 last reading kept", drv[27:0], pack(last_acc));

    // R12 strobes
    for (int i = 0; i < 6; i++) begin
      logic [7:0] m = 8'($urandom);
      rc_strobe_n = m;
      step(3);
      ex = {4'b0, pack(last_acc)};
      for (int g = 0; g < 8; g++) if (m[g]) ex[g*4 +: 4] = 4'b0;
      chk(drv[27:0] == ex[27:0] && (!m[7] || drv[31:28] == 4'b0), "R12 gating", drv, ex);
    end
    rc_strobe_n = 8'h00;
    step(3);

    // R10 trigger release timing
    rc_trig = 1;
    step(4);
    s0 = starts;
    rc_trig = 0;
    step(ST + 2);
    chk(conv_start == 1'b0, "R10 not yet", 32'(conv_start), 0);
    step(1);
    chk(conv_start == 1'b1, "R10 start after settle", 32'(conv_start), 1);
    // R11 second release during triggered conversion
    step(1);
    rc_trig = 1;
    step(3);
    rc_trig = 0;
    step(150);
    chk(starts == s0 + 1, "R11 one conversion only", starts, s0 + 1);
    chk(drv[27:0] == pack(last_acc), "R10 triggered reading published", drv[27:0], pack(last_acc));

    report();
    $finish;
  end
endmodule